// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

A general-purpose I/O port with one bit per pin (16 pins by default). Each pin has a direction bit, an input-enable bit and three sense bits (polarity, edge, both-edges). Pins that are inputs with their input enable set are synchronised, then sensed as a level or as an edge. The result lands in the data register, which doubles as the pin's interrupt flag. The data register also drives the output pins.

Software reaches the port through a word-addressed register bus with a write strobe, a byte address and combinational read data. The data register and the two interrupt masks each have four views: a plain word write, write-one-to-clear, write-one-to-set and write-one-to-toggle. Every view reads back the register behind it. A release view returns selected pins to their idle configuration.

Two registered interrupt lines, A and B, each report whether any data bit is set under that line's own mask.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` is 0, and both interrupt lines are low.
- R2: Data aliases act only on bits written as 1. Offset 0x04 clears, 0x08 sets and 0x0C inverts the bit. Offset 0x00 loads the whole word. Bits written as 0 leave the register unchanged.
- R3: Mask A sits at 0x10, with clear, set and toggle views at 0x14, 0x18 and 0x1C. Mask B uses the same pattern at 0x20 to 0x2C. The alias views behave as in R2.
- R4: The configuration words are direction at 0x30, polarity at 0x34, edge at 0x38, both-edges at 0x3C and input enable at 0x40. Each reads back what was written. Any alias offset reads the register behind it. `pin_out` equals the data register and `pin_oe` equals the direction register. Writes to addresses that are not word-aligned are ignored.
- R5: A pin is sensed when direction is 0 and input enable is 1. A sensed pin with edge 0 copies its synchronised input into its data bit, inverted when polarity is 1. The copy is visible within four clocks of the pin change.
- R6: A pin that is not sensed (input enable 0, or direction 1) never changes its data bit when its input changes.
- R7: A sensed pin with edge 1 and both-edges 0 sets its data bit on a rising input when polarity is 0, or on a falling input when polarity is 1. The bit stays set until it is cleared through 0x04. If a detected edge and a clear arrive in the same clock, the edge wins.
- R8: A sensed pin with edge 1 and both-edges 1 sets its data bit on either input transition.
- R9: `irq_a` is high one clock after the AND of data and mask A becomes nonzero. `irq_b` does the same with mask B.
- R10: Writing 1s to offset 0x44 clears mask A, mask B, direction, input enable, polarity, edge and both-edges for those pins. The data register and other pins are untouched. Offset 0x44 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data for `bus_addr`, combinational |
| pin_in | input | PIN_W | Pin input levels, asynchronous |
| pin_out | output | PIN_W | Output levels (data register) |
| pin_oe | output | PIN_W | Output enables (direction register) |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
A corrupted data or mask bit appears at once on `bus_rdata` and `pin_out`. It reaches `irq_a`/`irq_b` one clock later, so the bench reads back after every write and samples the interrupt lines a clock after each change. A wrong sense mode shows up only after the synchroniser and edge-history delay. Pin stimulus is therefore followed by a wait of several clocks before the data word is read. Ignored input changes are confirmed by reading the data word, which is the state they could have corrupted.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;
   // word index of each register view (byte offset = index * 4)
   typedef enum logic [4:0] {
      RG_DATA   = 5'd0,  RG_DCLR   = 5'd1,  RG_DSET   = 5'd2,  RG_DTGL   = 5'd3,
      RG_MA     = 5'd4,  RG_MA_CLR = 5'd5,  RG_MA_SET = 5'd6,  RG_MA_TGL = 5'd7,
      RG_MB     = 5'd8,  RG_MB_CLR = 5'd9,  RG_MB_SET = 5'd10, RG_MB_TGL = 5'd11,
      RG_DIR    = 5'd12, RG_POL    = 5'd13, RG_EDGE   = 5'd14, RG_BOTH   = 5'd15,
      RG_INEN   = 5'd16, RG_REL    = 5'd17
   } reg_idx_e;

   // low two index bits inside an aliased group select the write operation
   localparam logic [1:0] OP_LOAD = 2'd0;
   localparam logic [1:0] OP_CLR  = 2'd1;
   localparam logic [1:0] OP_SET  = 2'd2;
   localparam logic [1:0] OP_TGL  = 2'd3;

   localparam int N_GRP    = 3;   // data, mask A, mask B
   localparam int N_CFG    = 5;   // dir, pol, edge, both, inen
   localparam int CFG_BASE = 12;
   localparam int LAST_IDX = 17;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] inen,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] edg,
   input  logic [W-1:0] both,
   output logic [W-1:0] lvl_mask,
   output logic [W-1:0] lvl_val,
   output logic [W-1:0] edge_hit
);
   logic [W-1:0] prev;
   logic [W-1:0] sensed, rise, fall, picked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end

   always_comb begin
      sensed   = inen & ~dir;
      rise     = cur & ~prev;
      fall     = ~cur & prev;
      picked   = (both & (rise | fall)) | (~both & ((pol & fall) | (~pol & rise)));
      edge_hit = sensed & edg & picked;
      lvl_mask = sensed & ~edg;
      lvl_val  = cur ^ pol;
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_sense_pkg::*;
#(
   parameter int PIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [4:0]       widx,
   input  logic [PIN_W-1:0] wdata,
   input  logic [PIN_W-1:0] lvl_mask,
   input  logic [PIN_W-1:0] lvl_val,
   input  logic [PIN_W-1:0] edge_hit,
   output logic [PIN_W-1:0] data,
   output logic [PIN_W-1:0] mska,
   output logic [PIN_W-1:0] mskb,
   output logic [PIN_W-1:0] dir,
   output logic [PIN_W-1:0] pol,
   output logic [PIN_W-1:0] edg,
   output logic [PIN_W-1:0] both,
   output logic [PIN_W-1:0] inen
);
   function automatic logic [PIN_W-1:0] f_apply(input logic [PIN_W-1:0] cur,
                                                input logic [PIN_W-1:0] wd,
                                                input logic [1:0]       op);
      case (op)
         OP_LOAD: return wd;
         OP_CLR:  return cur & ~wd;
         OP_SET:  return cur | wd;
         default: return cur ^ wd;
      endcase
   endfunction

   logic [PIN_W-1:0] grp_q [N_GRP];
   logic [PIN_W-1:0] grp_d [N_GRP];
   logic [PIN_W-1:0] cfg_q [N_CFG];
   logic [PIN_W-1:0] cfg_d [N_CFG];
   logic             rel_hit;

   assign rel_hit = we && (widx == RG_REL);

   // aliased groups: data, mask A, mask B
   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic             bus_hit;
      logic [PIN_W-1:0] bus_nxt;
      assign bus_hit = we && (widx[4:2] == 3'(g));
      assign bus_nxt = bus_hit ? f_apply(grp_q[g], wdata, widx[1:0]) : grp_q[g];
      if (g == 0) begin : g_data
         // level pins follow the input, edge hits win over any bus write
         assign grp_d[g] = (bus_nxt & ~lvl_mask) | (lvl_val & lvl_mask) | edge_hit;
      end else begin : g_mask
         assign grp_d[g] = rel_hit ? (bus_nxt & ~wdata) : bus_nxt;
      end
   end

   // plain configuration words
   for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
      logic cfg_hit;
      assign cfg_hit  = we && (widx == 5'(CFG_BASE + k));
      assign cfg_d[k] = cfg_hit ? wdata : (rel_hit ? (cfg_q[k] & ~wdata) : cfg_q[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_GRP; i++) grp_q[i] <= '0;
         for (int i = 0; i < N_CFG; i++) cfg_q[i] <= '0;
      end else begin
         for (int i = 0; i < N_GRP; i++) grp_q[i] <= grp_d[i];
         for (int i = 0; i < N_CFG; i++) cfg_q[i] <= cfg_d[i];
      end
   end

   assign data = grp_q[0];
   assign mska = grp_q[1];
   assign mskb = grp_q[2];
   assign dir  = cfg_q[0];
   assign pol  = cfg_q[1];
   assign edg  = cfg_q[2];
   assign both = cfg_q[3];
   assign inen = cfg_q[4];
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
   import gpio_sense_pkg::*;
#(
   parameter int PIN_W       = 16,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_IRQ     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PIN_W-1:0]  bus_wdata,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe,
   output logic              irq_a,
   output logic              irq_b
);
   localparam int IDX_W = ADDR_W - 2;

   if (PIN_W < 1) begin : g_bad_width
      $error("gpio_sense_port: PIN_W must be positive");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_sense_port: ADDR_W must cover 18 word offsets");
   end

   logic [IDX_W-1:0] widx_full;
   logic [4:0]       widx;
   logic             in_map, we;

   assign widx_full = bus_addr[ADDR_W-1:2];
   assign in_map    = (bus_addr[1:0] == 2'b00) && (widx_full <= IDX_W'(LAST_IDX));
   assign widx      = widx_full[4:0];
   assign we        = bus_we && in_map;

   logic [PIN_W-1:0] data_q, mska_q, mskb_q, dir_q, pol_q, edg_q, both_q, inen_q;
   logic [PIN_W-1:0] pin_s, lvl_mask, lvl_val, edge_hit;

   gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_s)
   );

   gpio_sense #(.W(PIN_W)) u_sense (
      .clk(clk), .rst_n(rst_n), .cur(pin_s),
      .dir(dir_q), .inen(inen_q), .pol(pol_q), .edg(edg_q), .both(both_q),
      .lvl_mask(lvl_mask), .lvl_val(lvl_val), .edge_hit(edge_hit)
   );

   gpio_regfile #(.PIN_W(PIN_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(bus_wdata),
      .lvl_mask(lvl_mask), .lvl_val(lvl_val), .edge_hit(edge_hit),
      .data(data_q), .mska(mska_q), .mskb(mskb_q), .dir(dir_q),
      .pol(pol_q), .edg(edg_q), .both(both_q), .inen(inen_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (in_map) begin
         case (widx)
            RG_DATA, RG_DCLR, RG_DSET, RG_DTGL:         bus_rdata = data_q;
            RG_MA, RG_MA_CLR, RG_MA_SET, RG_MA_TGL:     bus_rdata = mska_q;
            RG_MB, RG_MB_CLR, RG_MB_SET, RG_MB_TGL:     bus_rdata = mskb_q;
            RG_DIR:                                     bus_rdata = dir_q;
            RG_POL:                                     bus_rdata = pol_q;
            RG_EDGE:                                    bus_rdata = edg_q;
            RG_BOTH:                                    bus_rdata = both_q;
            RG_INEN:                                    bus_rdata = inen_q;
            default:                                    bus_rdata = '0;
         endcase
      end
   end

   assign pin_out = data_q;
   assign pin_oe  = dir_q;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_a_q, irq_b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_a_q <= 1'b0;
            irq_b_q <= 1'b0;
         end else begin
            irq_a_q <= |(data_q & mska_q);
            irq_b_q <= |(data_q & mskb_q);
         end
      end
      assign irq_a = irq_a_q;
      assign irq_b = irq_b_q;
   end else begin : g_irq_comb
      assign irq_a = |(data_q & mska_q);
      assign irq_b = |(data_q & mskb_q);
   end
endmodule

// File: rtl/gpio_sense_chk.sv
module gpio_sense_chk #(
   parameter int PIN_W   = 16,
   parameter int ADDR_W  = 7,
   parameter bit REG_IRQ = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [PIN_W-1:0]  bus_wdata,
   input logic [PIN_W-1:0]  data,
   input logic [PIN_W-1:0]  mska,
   input logic [PIN_W-1:0]  mskb,
   input logic [PIN_W-1:0]  dir,
   input logic [PIN_W-1:0]  inen,
   input logic              irq_a,
   input logic              irq_b
);
   logic quiet, wr_dset, wr_dclr, wr_maclr, wr_mbset, wr_rel, wr_dgrp;

   assign quiet    = ((inen & ~dir) == '0);
   assign wr_dset  = bus_we && (bus_addr == ADDR_W'(8'h08));
   assign wr_dclr  = bus_we && (bus_addr == ADDR_W'(8'h04));
   assign wr_maclr = bus_we && (bus_addr == ADDR_W'(8'h14));
   assign wr_mbset = bus_we && (bus_addr == ADDR_W'(8'h28));
   assign wr_rel   = bus_we && (bus_addr == ADDR_W'(8'h44));
   assign wr_dgrp  = bus_we && (bus_addr < ADDR_W'(8'h10));

   // R2
   a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dset && quiet) |=> ((data & $past(bus_wdata)) == $past(bus_wdata)));
   // R2
   a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dclr && quiet) |=> ((data & $past(bus_wdata)) == '0));
   // R3
   a_r3_mska_clr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_maclr |=> ((mska & $past(bus_wdata)) == '0));
   // R3
   a_r3_mskb_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mbset |=> ((mskb & $past(bus_wdata)) == $past(bus_wdata)));
   // R6
   a_r6_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !wr_dgrp) |=> $stable(data));
   // R10
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rel |=> (((dir | inen | mska | mskb) & $past(bus_wdata)) == '0));

   if (REG_IRQ) begin : g_irq_chk
      // R9
      a_r9_irq_a_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (mska == '0) |=> !irq_a);
      // R9
      a_r9_irq_b_masked: assert property (@(posedge clk) disable iff (!rst_n)
         (mskb == '0) |=> !irq_b);
   end
endmodule

bind gpio_sense_port gpio_sense_chk #(
   .PIN_W(PIN_W), .ADDR_W(ADDR_W), .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .data(data_q), .mska(mska_q), .mskb(mskb_q),
   .dir(dir_q), .inen(inen_q), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/sim_gpio_sense_port.sv
`timescale 1ns/1ps
module sim_gpio_sense_port;
   localparam int PW = 16;
   localparam int AW = 7;

   localparam logic [AW-1:0] A_D   = 7'h00, A_DC  = 7'h04, A_DS  = 7'h08, A_DT  = 7'h0C;
   localparam logic [AW-1:0] A_MA  = 7'h10, A_MAC = 7'h14, A_MAS = 7'h18, A_MAT = 7'h1C;
   localparam logic [AW-1:0] A_MB  = 7'h20, A_MBC = 7'h24, A_MBS = 7'h28, A_MBT = 7'h2C;
   localparam logic [AW-1:0] A_DIR = 7'h30, A_POL = 7'h34, A_EDG = 7'h38, A_BTH = 7'h3C;
   localparam logic [AW-1:0] A_INE = 7'h40, A_REL = 7'h44;

   localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [PW-1:0] bus_wdata = '0;
   logic [PW-1:0] bus_rdata;
   logic [PW-1:0] pin_in = '0;
   logic [PW-1:0] pin_out, pin_oe;
   logic          irq_a, irq_b;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   gpio_sense_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b)
   );

   // driver side
   task automatic wr(input logic [AW-1:0] a, input logic [PW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [AW-1:0] a,
                              input logic [15:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      it.kind = kind; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor side
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
               K_RD:    act = bus_rdata;
               K_IRQ:   act = {14'd0, irq_b, irq_a};
               K_OUT:   act = pin_out;
               default: act = pin_oe;
            endcase
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;

      // R1 reset state
      expect_item(K_RD, A_D, 16'h0000, "R1 data");
      expect_item(K_RD, A_MA, 16'h0000, "R1 mask A");
      expect_item(K_RD, A_MB, 16'h0000, "R1 mask B");
      expect_item(K_RD, A_DIR, 16'h0000, "R1 dir");
      expect_item(K_RD, A_INE, 16'h0000, "R1 inen");
      expect_item(K_IRQ, A_D, 16'h0000, "R1 irq");
      expect_item(K_OE, A_D, 16'h0000, "R1 oe");

      // R2 data aliases
      wr(A_D, 16'h00F0);  expect_item(K_RD, A_D, 16'h00F0, "R2 load");
      wr(A_DS, 16'h0003); expect_item(K_RD, A_D, 16'h00F3, "R2 set");
      wr(A_DC, 16'h0030); expect_item(K_RD, A_D, 16'h00C3, "R2 clear");
      wr(A_DT, 16'h0101); expect_item(K_RD, A_D, 16'h01C2, "R2 toggle");
      wr(A_DS, 16'h0000); expect_item(K_RD, A_D, 16'h01C2, "R2 zero set");
      wr(A_DC, 16'h0000); expect_item(K_RD, A_D, 16'h01C2, "R2 zero clear");
      expect_item(K_RD, A_DC, 16'h01C2, "R4 alias read");
      expect_item(K_OUT, A_D, 16'h01C2, "R4 pin_out");

      // R3 masks
      wr(A_MA, 16'h1111);  expect_item(K_RD, A_MA, 16'h1111, "R3 A load");
      wr(A_MAS, 16'h0002); expect_item(K_RD, A_MA, 16'h1113, "R3 A set");
      wr(A_MAC, 16'h0011); expect_item(K_RD, A_MA, 16'h1102, "R3 A clear");
      wr(A_MAT, 16'h0003); expect_item(K_RD, A_MA, 16'h1101, "R3 A toggle");
      expect_item(K_RD, A_MAS, 16'h1101, "R3 A alias read");
      wr(A_MBS, 16'h8000); expect_item(K_RD, A_MB, 16'h8000, "R3 B set");
      wr(A_MBT, 16'h8001); expect_item(K_RD, A_MB, 16'h0001, "R3 B toggle");
      wr(A_MBC, 16'h0001); expect_item(K_RD, A_MBC, 16'h0000, "R3 B clear");
      wr(A_MBS, 16'h8000);

      // R9 interrupt lines
      expect_item(K_IRQ, A_D, 16'h0001, "R9 A only");
      wr(A_D, 16'h8000);  expect_item(K_IRQ, A_D, 16'h0002, "R9 B only");
      wr(A_MB, 16'h0000); expect_item(K_IRQ, A_D, 16'h0000, "R9 B masked");
      wr(A_MA, 16'h0000);
      wr(A_D, 16'h0000);

      // R4 configuration words
      wr(A_DIR, 16'h00FF); expect_item(K_RD, A_DIR, 16'h00FF, "R4 dir");
      expect_item(K_OE, A_D, 16'h00FF, "R4 pin_oe");
      wr(A_POL, 16'h1234); expect_item(K_RD, A_POL, 16'h1234, "R4 pol");
      wr(A_EDG, 16'h5678); expect_item(K_RD, A_EDG, 16'h5678, "R4 edge");
      wr(A_BTH, 16'h9ABC); expect_item(K_RD, A_BTH, 16'h9ABC, "R4 both");
      wr(A_INE, 16'h0F0F); expect_item(K_RD, A_INE, 16'h0F0F, "R4 inen");
      wr(A_DIR, 16'h0000); wr(A_POL, 16'h0000); wr(A_EDG, 16'h0000);
      wr(A_BTH, 16'h0000); wr(A_INE, 16'h0000);
      expect_item(K_RD, A_D, 16'h0000, "R4 data untouched");

      // R5 level sensing on pin 0
      wr(A_INE, 16'h0001);
      pin_in = 16'h0001; wait_n(4);
      expect_item(K_RD, A_D, 16'h0001, "R5 high level");
      pin_in = 16'h0000; wait_n(4);
      expect_item(K_RD, A_D, 16'h0000, "R5 low level");
      wr(A_POL, 16'h0001); wait_n(4);
      expect_item(K_RD, A_D, 16'h0001, "R5 active low");
      wr(A_INE, 16'h0000); wr(A_POL, 16'h0000); wr(A_D, 16'h0000);

      // R6 unsensed pins: pin 1 without enable, pin 2 as output
      wr(A_INE, 16'h0004); wr(A_DIR, 16'h0004);
      pin_in = 16'h0006; wait_n(4);
      expect_item(K_RD, A_D, 16'h0000, "R6 ignored input");
      pin_in = 16'h0000; wait_n(4);
      wr(A_DIR, 16'h0000); wr(A_INE, 16'h0000);

      // R7 single-edge sensing on pin 4
      wr(A_EDG, 16'h0010); wr(A_INE, 16'h0010);
      pin_in = 16'h0010; wait_n(5);
      expect_item(K_RD, A_D, 16'h0010, "R7 rising");
      pin_in = 16'h0000; wait_n(5);
      expect_item(K_RD, A_D, 16'h0010, "R7 sticky");
      wr(A_DC, 16'h0010); expect_item(K_RD, A_D, 16'h0000, "R7 cleared");
      wr(A_POL, 16'h0010);
      pin_in = 16'h0010; wait_n(5);
      expect_item(K_RD, A_D, 16'h0000, "R7 rise ignored");
      pin_in = 16'h0000; wait_n(5);
      expect_item(K_RD, A_D, 16'h0010, "R7 falling");
      wr(A_DC, 16'h0010); wr(A_POL, 16'h0000);

      // R8 both edges on pin 4
      wr(A_BTH, 16'h0010);
      pin_in = 16'h0010; wait_n(5);
      expect_item(K_RD, A_D, 16'h0010, "R8 rise");
      wr(A_DC, 16'h0010); expect_item(K_RD, A_D, 16'h0000, "R8 cleared");
      pin_in = 16'h0000; wait_n(5);
      expect_item(K_RD, A_D, 16'h0010, "R8 fall");

      // R9 edge flag reaching line B
      wr(A_MBS, 16'h0010); expect_item(K_IRQ, A_D, 16'h0002, "R9 edge irq");
      wr(A_DC, 16'h0010);  expect_item(K_IRQ, A_D, 16'h0000, "R9 flag cleared");

      // R10 release of pin 4
      wr(A_DIR, 16'h0030); wr(A_DS, 16'h0010); wr(A_MAS, 16'h0030);
      wr(A_REL, 16'h0010);
      expect_item(K_RD, A_DIR, 16'h0020, "R10 dir");
      expect_item(K_RD, A_MA, 16'h0020, "R10 mask A");
      expect_item(K_RD, A_MB, 16'h0000, "R10 mask B");
      expect_item(K_RD, A_INE, 16'h0000, "R10 inen");
      expect_item(K_RD, A_EDG, 16'h0000, "R10 edge");
      expect_item(K_RD, A_BTH, 16'h0000, "R10 both");
      expect_item(K_RD, A_REL, 16'h0000, "R10 reads zero");
      expect_item(K_RD, A_D, 16'h0010, "R10 data kept");

      wait_n(3);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule